// File: doc/BRIEF.md
# Power-Good Strap Latch Controller

This block watches a single strobe input that does double duty. Before configuration is latched, the strobe acts as a power-good indication. Once that indication has been seen, the block captures the board straps a single time: a three-bit frequency code, an output-routing select, a debug-clock select and a trusted-mode flag. From then on the same strobe is read as a live power-down request.

A mode pin sets the strobe's polarity. With mode 0, power-good is active low and power-down is active high. With mode 1, power-good is active high and power-down is active low. The mode in effect at capture stays fixed for power-down decoding after that.

All inputs first pass through a two-flop synchronizer. A capture happens only after the asserted level has been seen on two consecutive synchronized samples. After capture, strap and strobe changes no longer alter the latched values, with one exception: while the test-mode input is high, the latched values keep following the straps. In test mode, bit 1 of the frequency straps chooses between tri-stated outputs and a reference-divided output.

Top module: `pwrgood_strap_latch`

## Requirements
- R1: While reset is low, and directly after it: straps_latched_o=0, freq_code_o=0, route_sel_o=0, dbg_sel_o=0, trusted_o=1 and pwr_dn_o=0.
- R2: The strobe counts as asserted when pg_strobe_i equals pg_mode_i (mode 0: low, mode 1: high). Capture needs the asserted level on two consecutive synchronized samples, so a one-cycle pulse never captures.
- R3: On capture, freq_code_o takes fsel_i, route_sel_o takes route_strap_i, dbg_sel_o takes dbg_strap_i and trusted_o takes trust_strap_i, and straps_latched_o goes to 1 and stays there until reset. route_sel_o=0 means dot clock plus display clock, and 1 means 27 MHz pair plus serial reference 0. dbg_sel_o=1 means debug-port clock, and 0 means extra serial reference.
- R4: After capture, with test_mode_i low, changes on the straps, strobe or mode leave freq_code_o, route_sel_o, dbg_sel_o and trusted_o unchanged.
- R5: After capture, pwr_dn_o equals the synchronized strobe for a capture made in mode 0, and its inverse for a capture made in mode 1. Later mode changes are ignored.
- R6: pwr_dn_o stays 0 until capture.
- R7: After capture, while test_mode_i is high, the latched outputs follow the straps.
- R8: test_tristate_o = test_mode_i & ~fsel_i[1], and test_refdiv_o = test_mode_i & fsel_i[1]. The two are never both high.
- R9: Every input reaches the block's logic through two flops, so a strobe change shows on pwr_dn_o after the second rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg_mode_i | input | 1 | Strobe polarity/meaning select |
| pg_strobe_i | input | 1 | Power-good strobe, later power-down |
| fsel_i | input | 3 | Frequency-select straps |
| route_strap_i | input | 1 | Output-routing strap |
| dbg_strap_i | input | 1 | Debug-port clock strap |
| trust_strap_i | input | 1 | Trusted-mode strap |
| test_mode_i | input | 1 | Test mode enable |
| freq_code_o | output | 3 | Latched frequency code |
| route_sel_o | output | 1 | Latched routing select |
| dbg_sel_o | output | 1 | Latched debug-clock select |
| trusted_o | output | 1 | Latched trusted-mode flag |
| pwr_dn_o | output | 1 | Power-down request |
| straps_latched_o | output | 1 | Straps have been captured |
| test_tristate_o | output | 1 | Test mode: tri-state outputs |
| test_refdiv_o | output | 1 | Test mode: reference/N output |

## Verification
Power-down and the test-mode selects are decoded combinationally from the synchronizer outputs, so they follow a pin change after two rising edges. Capture needs one more edge for the confirm count, so latched values change on the fourth edge after the strobe asserts, assuming the strobe is held. The bench model pushes each sampled input into a queue and reads the entry that is two samples old, which reproduces that delay without copying the flop chain. Outputs are compared at each falling edge. The directed checks wait at least six cycles after a stimulus, except for one check that samples pwr_dn_o between the first and second edge to confirm the latency.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  localparam int FS_W = 3;

  typedef struct packed {
    logic            test;
    logic            trust;
    logic            dbg;
    logic            route;
    logic [FS_W-1:0] fs;
    logic            strobe;
    logic            mode;
  } pin_t;

  localparam int PIN_W = $bits(pin_t);

  typedef struct packed {
    logic            trust;
    logic            dbg;
    logic            route;
    logic [FS_W-1:0] fs;
  } cfg_t;

  // strobe idles high with mode 0 so the reset image is "not asserted"
  localparam pin_t PIN_RST = '{test: 1'b0, trust: 1'b1, dbg: 1'b0, route: 1'b0,
                               fs: '0, strobe: 1'b1, mode: 1'b0};
  localparam cfg_t CFG_RST = '{trust: 1'b1, dbg: 1'b0, route: 1'b0, fs: '0};

  // strobe level counts as power-good when it matches the mode polarity
  function automatic logic pg_level_hit(input logic mode, input logic lvl);
    return mode ? lvl : ~lvl;
  endfunction

  function automatic cfg_t pick_cfg(input pin_t p);
    cfg_t c;
    c.trust = p.trust;
    c.dbg   = p.dbg;
    c.route = p.route;
    c.fs    = p.fs;
    return c;
  endfunction
endpackage

// File: rtl/pgs_sync.sv
module pgs_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pgs_capture.sv
module pgs_capture
  import pgs_pkg::*;
#(
  parameter int CONFIRM = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  pin_t s,
  output logic lat,
  output logic hit,
  output cfg_t cfg
);
  localparam int              CNT_W   = (CONFIRM > 1) ? $clog2(CONFIRM) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CONFIRM - 1);

  logic             mode_q;
  logic [CNT_W-1:0] cnt;
  logic             cap_fire;
  logic             test_follow;

  assign hit         = pg_level_hit(lat ? mode_q : s.mode, s.strobe);
  assign cap_fire    = !lat && hit && (cnt == CNT_MAX);
  assign test_follow = lat && s.test;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat    <= 1'b0;
      mode_q <= 1'b0;
      cnt    <= '0;
      cfg    <= CFG_RST;
    end else begin
      if (!hit)               cnt <= '0;
      else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      if (cap_fire) begin
        lat    <= 1'b1;
        mode_q <= s.mode;
        cfg    <= pick_cfg(s);
      end else if (test_follow) begin
        cfg    <= pick_cfg(s);
      end
    end
  end

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lat |=> lat);
  assert_confirmed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lat) |-> ($past(hit) && $past(cnt) == CNT_MAX));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lat && !s.test) |=> $stable(cfg));
  assert_mode_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lat |=> $stable(mode_q));
endmodule

// File: rtl/pgs_pd_ctrl.sv
module pgs_pd_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic lat,
  input  logic hit,
  input  logic test,
  input  logic fs_mid,
  output logic pwr_dn,
  output logic tst_tri,
  output logic tst_ref
);
  assign pwr_dn  = lat && !hit;
  assign tst_tri = test && !fs_mid;
  assign tst_ref = test && fs_mid;

  assert_pd_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !lat |-> !pwr_dn);
  assert_test_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(tst_tri && tst_ref));
endmodule

// File: rtl/pwrgood_strap_latch.sv
module pwrgood_strap_latch
  import pgs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CONFIRM     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pg_mode_i,
  input  logic            pg_strobe_i,
  input  logic [FS_W-1:0] fsel_i,
  input  logic            route_strap_i,
  input  logic            dbg_strap_i,
  input  logic            trust_strap_i,
  input  logic            test_mode_i,
  output logic [FS_W-1:0] freq_code_o,
  output logic            route_sel_o,
  output logic            dbg_sel_o,
  output logic            trusted_o,
  output logic            pwr_dn_o,
  output logic            straps_latched_o,
  output logic            test_tristate_o,
  output logic            test_refdiv_o
);
  pin_t             raw;
  pin_t             s;
  logic [PIN_W-1:0] sync_q;
  logic             lat;
  logic             hit;
  cfg_t             cfg;

  assign raw = '{test: test_mode_i, trust: trust_strap_i, dbg: dbg_strap_i,
                 route: route_strap_i, fs: fsel_i, strobe: pg_strobe_i,
                 mode: pg_mode_i};

  pgs_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(sync_q));

  assign s = pin_t'(sync_q);

  pgs_capture #(.CONFIRM(CONFIRM)) u_cap (
    .clk(clk), .rst_n(rst_n), .s(s), .lat(lat), .hit(hit), .cfg(cfg));

  pgs_pd_ctrl u_pd (
    .clk(clk), .rst_n(rst_n), .lat(lat), .hit(hit), .test(s.test),
    .fs_mid(s.fs[1]), .pwr_dn(pwr_dn_o), .tst_tri(test_tristate_o),
    .tst_ref(test_refdiv_o));

  assign freq_code_o      = cfg.fs;
  assign route_sel_o      = cfg.route;
  assign dbg_sel_o        = cfg.dbg;
  assign trusted_o        = cfg.trust;
  assign straps_latched_o = lat;

  assert_reset_trust_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !lat |-> (trusted_o && freq_code_o == '0 && !route_sel_o && !dbg_sel_o));
endmodule

// File: tb/test_pwrgood_strap_latch.sv
module test_pwrgood_strap_latch;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic mode = 0, strobe = 1, route = 0, dbg = 0, trust = 1, test = 0;
  logic [2:0] fs = 0;
  logic [2:0] freq_o;
  logic route_o, dbg_o, trust_o, pd_o, lat_o, tri_o, ref_o;
  int total = 0, bad = 0;

  always #(PERIOD/2) clk = ~clk;

  pwrgood_strap_latch i_pwrgood_strap_latch (
    .clk(clk), .rst_n(rst_n), .pg_mode_i(mode), .pg_strobe_i(strobe),
    .fsel_i(fs), .route_strap_i(route), .dbg_strap_i(dbg),
    .trust_strap_i(trust), .test_mode_i(test), .freq_code_o(freq_o),
    .route_sel_o(route_o), .dbg_sel_o(dbg_o), .trusted_o(trust_o),
    .pwr_dn_o(pd_o), .straps_latched_o(lat_o), .test_tristate_o(tri_o),
    .test_refdiv_o(ref_o));

  // reference model; input word = {test,trust,dbg,route,fs[2:0],strobe,mode}
  logic [8:0] hist[$];
  bit m_lat, m_mode, m_prev, m_route, m_dbg, m_trust;
  bit [2:0] m_fs;

  function automatic logic [8:0] seen();
    if (hist.size() < 2) return 9'b0_1_0_0_000_1_0;
    return hist[hist.size()-2];
  endfunction

  function automatic bit level_ok(logic [8:0] w);
    bit pol = m_lat ? m_mode : w[0];
    return (w[1] == pol);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist.delete();
      m_lat = 0; m_mode = 0; m_prev = 0; m_route = 0; m_dbg = 0;
      m_trust = 1; m_fs = 0;
    end else begin
      logic [8:0] w;
      bit ok;
      w  = seen();
      ok = level_ok(w);
      if ((!m_lat && ok && m_prev) || (m_lat && w[8])) begin
        if (!m_lat) m_mode = w[0];
        m_lat = 1;
        m_fs = w[4:2]; m_route = w[5]; m_dbg = w[6]; m_trust = w[7];
      end
      m_prev = ok;
      hist.push_back({test, trust, dbg, route, fs, strobe, mode});
      if (hist.size() > 4) void'(hist.pop_front());
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    logic [8:0] w;
    w = seen();
    chk("R3", "freq_code", freq_o, m_fs);
    chk("R3", "route_sel", route_o, m_route);
    chk("R3", "dbg_sel", dbg_o, m_dbg);
    chk("R3", "trusted", trust_o, m_trust);
    chk("R2", "latched", lat_o, m_lat);
    chk("R5", "pwr_dn", pd_o, m_lat && !level_ok(w));
    chk("R8", "tristate", tri_o, w[8] && !w[3]);
    chk("R8", "refdiv", ref_o, w[8] && w[3]);
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 50000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state with straps already driven
    fs = 5; route = 1; dbg = 1; trust = 0;
    wait_cyc(3);
    chk("R1", "latched", lat_o, 0); chk("R1", "trusted", trust_o, 1);
    chk("R1", "freq", freq_o, 0);   chk("R1", "pwr_dn", pd_o, 0);
    rst_n = 1;
    wait_cyc(6);
    chk("R6", "pwr_dn before capture", pd_o, 0);
    chk("R1", "latched after release", lat_o, 0);
    // R2: one-cycle pulse must not capture
    strobe = 0; wait_cyc(1); strobe = 1;
    wait_cyc(6);
    chk("R2", "pulse ignored", lat_o, 0);
    // R3: held assertion captures in mode 0
    strobe = 0;
    wait_cyc(6);
    chk("R3", "latched", lat_o, 1);   chk("R3", "freq", freq_o, 5);
    chk("R3", "route", route_o, 1);   chk("R3", "dbg", dbg_o, 1);
    chk("R3", "trusted", trust_o, 0); chk("R6", "pwr_dn idle", pd_o, 0);
    // R4: strap changes ignored
    fs = 2; route = 0; dbg = 0; trust = 1; mode = 1;
    wait_cyc(6);
    chk("R4", "freq held", freq_o, 5); chk("R4", "trusted held", trust_o, 0);
    // R5/R9: power-down active high, mode-1 pin ignored, two-edge latency
    strobe = 1;
    wait_cyc(1);
    chk("R9", "pwr_dn after one edge", pd_o, 0);
    wait_cyc(1);
    chk("R5", "pwr_dn asserted", pd_o, 1);
    chk("R4", "latched kept", lat_o, 1);
    strobe = 0; wait_cyc(3);
    chk("R5", "pwr_dn released", pd_o, 0);
    // R7/R8: test mode follows straps
    test = 1; fs = 3; wait_cyc(6);
    chk("R7", "freq follows", freq_o, 3); chk("R7", "trusted follows", trust_o, 1);
    chk("R8", "refdiv", ref_o, 1);        chk("R8", "tristate", tri_o, 0);
    fs = 4; wait_cyc(6);
    chk("R7", "freq follows 4", freq_o, 4); chk("R8", "tristate", tri_o, 1);
    test = 0; wait_cyc(3); fs = 7; wait_cyc(6);
    chk("R4", "freq held after test", freq_o, 4);
    // mode 1 capture after new reset
    rst_n = 0; mode = 1; strobe = 0; fs = 6; route = 1; dbg = 0; trust = 1;
    wait_cyc(2);
    chk("R1", "latched cleared", lat_o, 0);
    rst_n = 1; wait_cyc(6);
    chk("R2", "mode1 low not asserted", lat_o, 0);
    strobe = 1; wait_cyc(6);
    chk("R3", "mode1 latched", lat_o, 1); chk("R3", "mode1 freq", freq_o, 6);
    mode = 0; strobe = 0; wait_cyc(4);
    chk("R5", "mode1 pwr_dn active low", pd_o, 1);
    strobe = 1; wait_cyc(4);
    chk("R5", "mode1 pwr_dn released", pd_o, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule